// File: doc/BRIEF.md
# PWM Time Base Generator

This block is the counting core behind a PWM unit. A 15-bit timer advances once per prescaled tick. The tick comes from an instruction-rate clock enable divided by 1, 4, 16 or 64. The timer runs in one of three ways:

- **Free-running:** it counts up and wraps to zero.
- **Single-shot:** it runs one period and then switches itself off.
- **Up/down:** it climbs to the period value, then descends back to zero.

Each time the timer reaches its period, the block emits a one-cycle match pulse. A programmable postscaler divides those matches into a slower event pulse.

Software never writes the active period directly. It writes a period buffer, and the block copies the buffer into the active period at a safe point in the waveform. In free-running and single-shot modes that point is the wrap. In up/down modes it is the bottom turn. While the time base is disabled, the copy happens at once.

A bus-style write interface loads three things: the timer, a control word, and the period buffer. The control word holds enable, mode, prescale and postscale. Writing the timer or the control word restarts both divider counters. Writing the control word never disturbs the timer value.

Top module: `pwm_timebase`

## Requirements
- R1: The prescale field `ctl_ckps` selects how many enabled `tcy_en` cycles make one timer tick: code 0 gives 1, code 1 gives 4, code 2 gives 16 and code 3 gives 64. Cycles with `tcy_en` low do not count.
- R2: Writing the timer or the control word, or applying reset, clears both the prescale counter and the postscale counter. The tick in that write cycle is dropped.
- R3: A control-word write leaves `tmr_o` unchanged in the following cycle.
- R4: Free-running mode (`ctl_mode` = 0) counts 0,1,…,P and then returns to 0. `match_o` is high for the one cycle in which `tmr_o` has just become 0 after the wrap, so matches are (P+1) ticks apart.
- R5: `event_o` is high on every (S+1)-th `match_o`, where S is `ctl_ops`, and only together with `match_o`.
- R6: In free-running mode, a period-buffer write made while running takes effect only at the next wrap. The period in progress keeps its old length.
- R7: Up/down modes (`ctl_mode` = 2 or 3) count up from 0 to P with `dir_o` = 0. At P, `dir_o` goes to 1, and `match_o` pulses with `tmr_o` = P. The timer then counts down to 0, where `dir_o` returns to 0. Matches are 2·(P+1) ticks apart.
- R8: In up/down modes the period buffer is copied into the active period only at the bottom turn, when the timer is 0 while counting down.
- R9: While disabled, the timer holds its value and the active period follows the buffer every cycle.
- R10: Single-shot mode (`ctl_mode` = 1) runs one period and wraps to 0 with a single `match_o`. It then clears its own enable, and the timer stays at 0.
- R11: A timer write loads `tmr_wdata` into `tmr_o` at the next clock edge. It takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tcy_en | input | 1 | Instruction-rate clock enable feeding the prescaler |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 15 | Timer write value |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_en | input | 1 | Control: time base enable |
| ctl_mode | input | 2 | Control: 0 free-running, 1 single-shot, 2/3 up/down |
| ctl_ckps | input | 2 | Control: prescale select |
| ctl_ops | input | 4 | Control: postscale select, divide by value+1 |
| per_wr | input | 1 | Period-buffer write strobe |
| per_wdata | input | 15 | Period-buffer write value |
| tmr_o | output | 15 | Current timer value |
| dir_o | output | 1 | Count direction, 1 while counting down |
| match_o | output | 1 | One-cycle period-match pulse |
| event_o | output | 1 | One-cycle postscaled event pulse |

## Verification
Several rules hold cycle by cycle, and the bound checker watches them continuously:

- a timer write loads its value, and a control write freezes the timer for a cycle;
- a disabled timer holds, and a disabled time base tracks the buffer into the active period;
- every event coincides with a match;
- free-running matches land on zero, and up/down matches land while counting down;
- single-shot matches drop the enable;
- direction stays low outside up/down modes.

Spacing cannot be seen in any single cycle: tick ratios, period lengths, postscale division, the deferred period reload and the restart of the dividers after a write. The bench measures these over whole periods, across sweeps of prescale, period and postscale settings, and compares the gaps with values computed arithmetically.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_UPDN    = 2'd2,
    MODE_UPDN_B  = 2'd3
  } pwm_mode_e;

  localparam int PRE_CW = 6;

  function automatic logic [PRE_CW-1:0] presc_limit(input logic [1:0] sel);
    logic [PRE_CW-1:0] lim;
    case (sel)
      2'd0:    lim = 6'd0;
      2'd1:    lim = 6'd3;
      2'd2:    lim = 6'd15;
      default: lim = 6'd63;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_tb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_CW-1:0] cnt_q, cnt_d;
  logic [PRE_CW-1:0] lim;

  always_comb begin
    lim  = presc_limit(sel);
    tick = run && !clr && (cnt_q == lim);
    if (clr)
      cnt_d = '0;
    else if (tick)
      cnt_d = '0;
    else if (run)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            fire
);

  logic [PS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    fire = hit && (cnt_q == sel);
    if (clr)
      cnt_d = '0;
    else if (fire)
      cnt_d = '0;
    else if (hit)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_tb_pkg::*;
#(
  parameter int TMR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  pwm_mode_e        mode,
  input  logic             en,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic [TMR_W-1:0] per_buf,
  output logic [TMR_W-1:0] tmr,
  output logic             dir,
  output logic [TMR_W-1:0] per_act,
  output logic             hit,
  output logic             oneshot_done
);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [TMR_W-1:0] per_q, per_d;
  logic             dir_q, dir_d;
  logic             updn;
  logic             reload;

  always_comb begin
    updn   = mode[1];
    tmr_d  = tmr_q;
    dir_d  = updn ? dir_q : 1'b0;
    per_d  = per_q;
    hit    = 1'b0;
    reload = 1'b0;
    if (tmr_wr) begin
      tmr_d = tmr_wdata;
    end else if (tick) begin
      if (!updn) begin
        if (tmr_q >= per_q) begin
          tmr_d  = '0;
          hit    = 1'b1;
          reload = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end else if (!dir_q) begin
        if (tmr_q >= per_q) begin
          dir_d = 1'b1;
          hit   = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end else begin
        if (tmr_q == '0) begin
          dir_d  = 1'b0;
          reload = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
    end
    if (!en || reload) per_d = per_buf;
    oneshot_done = hit && (mode == MODE_ONESHOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      dir_q <= 1'b0;
      per_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      dir_q <= dir_d;
      per_q <= per_d;
    end
  end

  assign tmr     = tmr_q;
  assign dir     = dir_q;
  assign per_act = per_q;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int TMR_W = 15,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tcy_en,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic [1:0]       ctl_mode,
  input  logic [1:0]       ctl_ckps,
  input  logic [PS_W-1:0]  ctl_ops,
  input  logic             per_wr,
  input  logic [TMR_W-1:0] per_wdata,
  output logic [TMR_W-1:0] tmr_o,
  output logic             dir_o,
  output logic             match_o,
  output logic             event_o
);

  logic             rst_meta_q, rst_s_n;
  logic             en_q, en_d;
  pwm_mode_e        mode_q, mode_d;
  logic [1:0]       ckps_q, ckps_d;
  logic [PS_W-1:0]  ops_q, ops_d;
  logic [TMR_W-1:0] per_buf_q, per_buf_d;
  logic [TMR_W-1:0] per_act;
  logic             match_q, event_q;
  logic             div_clr, tick, hit, fire, oneshot_done;

  // Reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  assign div_clr = tmr_wr | ctl_wr;

  always_comb begin
    en_d      = en_q;
    mode_d    = mode_q;
    ckps_d    = ckps_q;
    ops_d     = ops_q;
    per_buf_d = per_buf_q;
    if (ctl_wr) begin
      en_d   = ctl_en;
      mode_d = pwm_mode_e'(ctl_mode);
      ckps_d = ctl_ckps;
      ops_d  = ctl_ops;
    end else if (oneshot_done) begin
      en_d = 1'b0;
    end
    if (per_wr) per_buf_d = per_wdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q      <= 1'b0;
      mode_q    <= MODE_FREE;
      ckps_q    <= '0;
      ops_q     <= '0;
      per_buf_q <= '0;
      match_q   <= 1'b0;
      event_q   <= 1'b0;
    end else begin
      en_q      <= en_d;
      mode_q    <= mode_d;
      ckps_q    <= ckps_d;
      ops_q     <= ops_d;
      per_buf_q <= per_buf_d;
      match_q   <= hit;
      event_q   <= fire;
    end
  end

  pwm_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (tcy_en & en_q),
    .clr   (div_clr),
    .sel   (ckps_q),
    .tick  (tick)
  );

  pwm_counter #(.TMR_W(TMR_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .tick         (tick),
    .mode         (mode_q),
    .en           (en_q),
    .tmr_wr       (tmr_wr),
    .tmr_wdata    (tmr_wdata),
    .per_buf      (per_buf_q),
    .tmr          (tmr_o),
    .dir          (dir_o),
    .per_act      (per_act),
    .hit          (hit),
    .oneshot_done (oneshot_done)
  );

  pwm_postscaler #(.PS_W(PS_W)) u_post (
    .clk   (clk),
    .rst_n (rst_s_n),
    .hit   (hit),
    .clr   (div_clr),
    .sel   (ops_q),
    .fire  (fire)
  );

  assign match_o = match_q;
  assign event_o = event_q;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int TMR_W = 15
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             tmr_wr,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic             ctl_wr,
  input logic             en_q,
  input logic [1:0]       mode_q,
  input logic [TMR_W-1:0] per_buf_q,
  input logic [TMR_W-1:0] per_act,
  input logic [TMR_W-1:0] tmr_o,
  input logic             dir_o,
  input logic             match_o,
  input logic             event_o
);

  AST_TMR_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_s_n)
    tmr_wr |=> tmr_o == $past(tmr_wdata));  // R11

  AST_CTL_WRITE_KEEPS_TMR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl_wr && !tmr_wr) |=> tmr_o == $past(tmr_o));  // R3

  AST_IDLE_HOLDS_TMR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!en_q && !tmr_wr) |=> tmr_o == $past(tmr_o));  // R9

  AST_IDLE_COPIES_PERIOD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en_q |=> per_act == $past(per_buf_q));  // R9

  AST_EVENT_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_s_n)
    event_o |-> match_o);  // R5

  AST_FREE_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (match_o && mode_q == 2'd0) |-> tmr_o == '0);  // R4

  AST_UPDN_MATCH_TURNS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (match_o && mode_q[1]) |-> dir_o);  // R7

  AST_DIR_LOW_OUTSIDE_UPDN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mode_q[1] && !ctl_wr) |=> !dir_o);  // R7

  AST_ONESHOT_DISABLES: assert property (@(posedge clk) disable iff (!rst_s_n)
    (match_o && mode_q == 2'd1) |-> (!en_q && tmr_o == '0));  // R10

endmodule

bind pwm_timebase pwm_timebase_chk #(.TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .tmr_wr    (tmr_wr),
  .tmr_wdata (tmr_wdata),
  .ctl_wr    (ctl_wr),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .per_buf_q (per_buf_q),
  .per_act   (per_act),
  .tmr_o     (tmr_o),
  .dir_o     (dir_o),
  .match_o   (match_o),
  .event_o   (event_o)
);

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tcy_en = 1'b1;
  logic        tmr_wr = 1'b0;
  logic [14:0] tmr_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic        ctl_en = 1'b0;
  logic [1:0]  ctl_mode = '0;
  logic [1:0]  ctl_ckps = '0;
  logic [3:0]  ctl_ops = '0;
  logic        per_wr = 1'b0;
  logic [14:0] per_wdata = '0;
  logic [14:0] tmr_o;
  logic        dir_o, match_o, event_o;
  logic        tcy_half = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  always @(negedge clk) tcy_en <= tcy_half ? ~tcy_en : 1'b1;

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .tcy_en(tcy_en),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
    .ctl_ckps(ctl_ckps), .ctl_ops(ctl_ops),
    .per_wr(per_wr), .per_wdata(per_wdata),
    .tmr_o(tmr_o), .dir_o(dir_o), .match_o(match_o), .event_o(event_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tmr_wr = 1'b0; ctl_wr = 1'b0; per_wr = 1'b0;
  endtask

  task automatic cfg(input logic en, input logic [1:0] mode,
                     input logic [1:0] ck, input logic [3:0] ops);
    @(negedge clk);
    ctl_en = en; ctl_mode = mode; ctl_ckps = ck; ctl_ops = ops; ctl_wr = 1'b1;
    step();
  endtask

  task automatic set_per(input int p);
    @(negedge clk);
    per_wdata = 15'(p); per_wr = 1'b1;
    step();
  endtask

  task automatic set_tmr(input int v);
    @(negedge clk);
    tmr_wdata = 15'(v); tmr_wr = 1'b1;
    step();
  endtask

  // counts negedges until the chosen pulse is seen (0 = match, 1 = event)
  task automatic gap(input int which, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!((which == 0) ? match_o : event_o) && n < 5000);
  endtask

  task automatic start(input logic [1:0] mode, input int p,
                       input logic [1:0] ck, input logic [3:0] ops);
    cfg(1'b0, mode, ck, ops);
    set_per(p);
    set_tmr(0);
    cfg(1'b1, mode, ck, ops);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, v, cnt;
    repeat (3) @(negedge clk);
    chk("R2 reset tmr", tmr_o, 0);
    chk("R2 reset dir", dir_o, 0);
    chk("R2 reset match", match_o, 0);
    chk("R2 reset event", event_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R4: prescale x period sweep, free-running
    for (int ck = 0; ck < 4; ck++) begin
      for (int pi = 0; pi < 2; pi++) begin
        int p = (pi == 0) ? 0 : 3;
        start(2'd0, p, 2'(ck), 4'd0);
        gap(0, n);
        gap(0, n);
        chk($sformatf("R1 R4 free ck=%0d P=%0d gap", ck, p), n, (1 << (2*ck)) * (p + 1));
      end
    end
    start(2'd0, 6, 2'd0, 4'd0);
    gap(0, n);
    chk("R4 tmr at match", tmr_o, 0);

    // R1: tcy_en at half rate doubles the gap
    tcy_half = 1'b1;
    start(2'd0, 3, 2'd0, 4'd0);
    gap(0, n); gap(0, n);
    chk("R1 half-rate tcy gap", n, 8);
    tcy_half = 1'b0;

    // R5: postscale sweep
    for (int s = 0; s < 4; s++) begin
      start(2'd0, 2, 2'd0, 4'(s));
      gap(1, n); gap(1, n);
      chk($sformatf("R5 event gap S=%0d", s), n, (s + 1) * 3);
    end

    // R7: up/down
    for (int ck = 0; ck < 2; ck++) begin
      start(2'd2, 3, 2'(ck), 4'd0);
      gap(0, n); gap(0, n);
      chk($sformatf("R7 updown gap ck=%0d", ck), n, 2 * 4 * (1 << (2*ck)));
      chk("R7 dir at match", dir_o, 1);
      chk("R7 tmr at match", tmr_o, 3);
    end
    start(2'd3, 2, 2'd0, 4'd0);
    gap(0, n); gap(0, n);
    chk("R7 mode3 updown gap", n, 6);

    // R6: free-running buffer deferred to wrap
    start(2'd0, 9, 2'd0, 4'd0);
    gap(0, n);
    per_wdata = 15'd4; per_wr = 1'b1;
    gap(0, n);
    chk("R6 old period kept", n, 10);
    gap(0, n);
    chk("R6 new period at wrap", n, 5);

    // R8: up/down buffer loads at bottom
    start(2'd2, 5, 2'd0, 4'd0);
    gap(0, n);
    per_wdata = 15'd2; per_wr = 1'b1;
    gap(0, n);
    chk("R8 transition gap", n, 9);
    gap(0, n);
    chk("R8 new updown gap", n, 6);

    // R9: disabled transfer and hold
    cfg(1'b0, 2'd0, 2'd0, 4'd0);
    set_per(7);
    set_tmr(0);
    cfg(1'b1, 2'd0, 2'd0, 4'd0);
    gap(0, n); gap(0, n);
    chk("R9 immediate buffer transfer", n, 8);

    // R3 / R9: control write keeps timer, disabled timer holds
    start(2'd0, 200, 2'd0, 4'd0);
    repeat (30) step();
    @(negedge clk);
    v = tmr_o;
    ctl_en = 1'b0; ctl_wr = 1'b1;
    step();
    chk("R3 ctl write keeps tmr", tmr_o, v);
    repeat (5) step();
    chk("R9 disabled tmr holds", tmr_o, v);

    // R11 / R2: timer write and prescaler restart
    start(2'd0, 200, 2'd2, 4'd0);
    repeat (37) step();
    set_tmr(50);
    chk("R11 timer write", tmr_o, 50);
    repeat (15) step();
    chk("R2 prescaler restarted, no tick yet", tmr_o, 50);
    step();
    chk("R2 prescaler restarted, tick", tmr_o, 51);

    // R2: postscaler cleared by control write
    start(2'd0, 1, 2'd0, 4'd2);
    gap(1, n);
    gap(0, n);
    cfg(1'b1, 2'd0, 2'd0, 4'd2);
    cnt = 0;
    n = 0;
    do begin
      step();
      n++;
      if (match_o) cnt++;
    end while (!event_o && n < 1000);
    chk("R2 postscaler restart matches", cnt, 3);

    // R10: single-shot
    start(2'd1, 3, 2'd0, 4'd0);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (match_o) cnt++;
    end
    chk("R10 single match", cnt, 1);
    chk("R10 stopped at zero", tmr_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule